// File: doc/BRIEF.md
# PCI Target Read Retry Controller

This block decides how a PCI target answers each request while posted writes wait in a write FIFO. The surrounding target logic reports each new address phase as a one-cycle `req_start` strobe, with its direction, address and byte enables. The block answers with a single-cycle low pulse on either `trdy_n`, which completes the request, or `stop_n`, which retries it. It asks the local side for read data with `lcl_rd_req`, and the local side reports the fetched data with `lcl_data_rdy`. The bus side issues a new request only after it has seen the answer to the previous one.

Two read policies are selectable. In compliant mode, a read becomes a delayed read. The first attempt is retried while the local fetch runs. A later repeat with the same address and byte enables completes once the data is back. A write can optionally discard the pending delayed read. In legacy mode, the target holds the bus until the data arrives. A retry-delay counter, loaded from a 4-bit field, limits this wait. Independently of the mode, the write-FIFO occupancy decides whether a request must be retried. A reserve option keeps one FIFO slot free for a read address.

Top module: `pci_rd_retry_ctl`

## Requirements
- R1: After reset, `trdy_n` and `stop_n` are 1, and `lcl_rd_req` and `dr_pending` are 0.
- R2: In compliant mode, a read with no delayed read pending is answered by a `stop_n` pulse one clock after `req_start`. In the same cycle `lcl_rd_req` pulses and `dr_pending` becomes 1.
- R3: In compliant mode, a repeat read whose address and byte enables match the pending delayed read gets a `stop_n` pulse while the data is still outstanding. Once `lcl_data_rdy` has been seen, the repeat gets a `trdy_n` pulse one clock after `req_start`, and `dr_pending` returns to 0.
- R4: In compliant mode, a read that differs from the pending delayed read in address or in byte enables gets a `stop_n` pulse. It does not pulse `lcl_rd_req`, and `dr_pending` stays 1.
- R5: In legacy mode, a read pulses `lcl_rd_req` one clock after `req_start`. It then gets a `trdy_n` pulse k clocks after `req_start` if `lcl_data_rdy` is high at the k-th edge (k ≥ 1) and the timeout has not yet fired. Data arriving on the edge where the timeout would fire still wins.
- R6: In legacy mode, a read whose data never arrives gets a `stop_n` pulse `cfg_retry_dly`×8+1 clocks after `req_start`.
- R7: With both `cfg_compliant` and `cfg_flush` at 1, any write start clears `dr_pending`, so the next read starts a new local fetch.
- R8: With `cfg_flush` at 0, a write leaves a pending delayed read and its fetched data intact.
- R9: With `cfg_reserve` at 1, writes are retried once `wf_count` ≥ FIFO_DEPTH−1 and accepted below that. Reads are never retried because of occupancy.
- R10: With `cfg_reserve` at 0, writes and reads are retried when `wf_count` = FIFO_DEPTH, and such a read does not pulse `lcl_rd_req`. Writes are accepted at FIFO_DEPTH−1.
- R11: `trdy_n` and `stop_n` are never low together, and each low pulse lasts exactly one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_compliant | input | 1 | 1 = delayed-read mode, 0 = legacy hold mode |
| cfg_flush | input | 1 | A write discards the pending delayed read (compliant mode only) |
| cfg_reserve | input | 1 | Keep one write-FIFO slot free for a read address |
| cfg_retry_dly | input | DLY_W | Legacy wait limit in units of DLY_SCALE clocks |
| req_start | input | 1 | One-cycle strobe at each new address phase |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Request address |
| req_be | input | BE_W | Request byte enables |
| wf_count | input | $clog2(FIFO_DEPTH+1) | Current write-FIFO occupancy |
| lcl_data_rdy | input | 1 | Local read data is available |
| lcl_rd_req | output | 1 | One-cycle pulse that starts a local read |
| trdy_n | output | 1 | Active-low completion pulse |
| stop_n | output | 1 | Active-low retry pulse |
| dr_pending | output | 1 | A delayed read is outstanding |

## Verification
The bench builds the block with FIFO_DEPTH=4 and ADDR_W=16, keeping the default retry scale of 8. The small depth puts both the full level and the one-below-full level within a 3-bit count, so every reserve and no-reserve threshold is exercised directly. Retry-delay values 0, 1 and 2 give timeouts of 1, 9 and 17 clocks. These values let the bench measure the zero case, the scale step, and a data arrival on the exact edge the timer expires.

// File: rtl/rdrt_pkg.sv
package rdrt_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_WAIT = 1'b1
    } rdrt_state_e;
endpackage

// File: rtl/rdrt_fifo_gate.sv
module rdrt_fifo_gate #(
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic [CNT_W-1:0] wf_count,
    input  logic             reserve,
    output logic             wr_block,
    output logic             rd_block
);
    localparam logic [CNT_W-1:0] FULL_LVL = CNT_W'(FIFO_DEPTH);
    localparam logic [CNT_W-1:0] EARLY_LVL = CNT_W'(FIFO_DEPTH - 1);

    always_comb begin
        wr_block = reserve ? (wf_count >= EARLY_LVL) : (wf_count >= FULL_LVL);
        rd_block = !reserve && (wf_count >= FULL_LVL);
    end
endmodule

// File: rtl/rdrt_retry_timer.sv
module rdrt_retry_timer #(
    parameter int DLY_W = 4,
    parameter int DLY_SCALE = 8,
    localparam int TMR_W = DLY_W + $clog2(DLY_SCALE) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DLY_W-1:0] dly,
    input  logic             run,
    output logic             expired
);
    logic [TMR_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = TMR_W'(dly) * TMR_W'(DLY_SCALE);
        end else if (run && cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/pci_rd_retry_ctl.sv
module pci_rd_retry_ctl
    import rdrt_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int BE_W = 4,
    parameter int FIFO_DEPTH = 8,
    parameter int DLY_W = 4,
    parameter int DLY_SCALE = 8,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_compliant,
    input  logic              cfg_flush,
    input  logic              cfg_reserve,
    input  logic [DLY_W-1:0]  cfg_retry_dly,
    input  logic              req_start,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BE_W-1:0]   req_be,
    input  logic [CNT_W-1:0]  wf_count,
    input  logic              lcl_data_rdy,
    output logic              lcl_rd_req,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              dr_pending
);
    typedef struct packed {
        rdrt_state_e       st;
        logic              trdy_n;
        logic              stop_n;
        logic              rd_req;
        logic              dr_pend;
        logic              dr_rdy;
        logic [ADDR_W-1:0] dr_addr;
        logic [BE_W-1:0]   dr_be;
    } ctl_s;

    ctl_s q, d;
    logic wr_block, rd_block;
    logic tmr_load, tmr_expired;
    logic dr_match;

    rdrt_fifo_gate #(.FIFO_DEPTH(FIFO_DEPTH)) u_gate (
        .wf_count (wf_count),
        .reserve  (cfg_reserve),
        .wr_block (wr_block),
        .rd_block (rd_block)
    );

    rdrt_retry_timer #(.DLY_W(DLY_W), .DLY_SCALE(DLY_SCALE)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .dly     (cfg_retry_dly),
        .run     (q.st == ST_WAIT),
        .expired (tmr_expired)
    );

    assign dr_match = (req_addr == q.dr_addr) && (req_be == q.dr_be);

    always_comb begin
        d = q;
        d.trdy_n = 1'b1;
        d.stop_n = 1'b1;
        d.rd_req = 1'b0;
        tmr_load = 1'b0;

        // capture arrival of delayed-read data
        if (cfg_compliant && q.dr_pend && lcl_data_rdy) d.dr_rdy = 1'b1;

        unique case (q.st)
            ST_IDLE: begin
                if (req_start) begin
                    if (req_write) begin
                        if (wr_block) d.stop_n = 1'b0;
                        else          d.trdy_n = 1'b0;
                        if (cfg_compliant && cfg_flush) begin
                            d.dr_pend = 1'b0;
                            d.dr_rdy  = 1'b0;
                        end
                    end else if (rd_block) begin
                        d.stop_n = 1'b0;
                    end else if (cfg_compliant) begin
                        if (q.dr_pend) begin
                            if (dr_match && q.dr_rdy) begin
                                d.trdy_n  = 1'b0;
                                d.dr_pend = 1'b0;
                                d.dr_rdy  = 1'b0;
                            end else begin
                                d.stop_n = 1'b0;
                            end
                        end else begin
                            d.dr_pend = 1'b1;
                            d.dr_rdy  = 1'b0;
                            d.dr_addr = req_addr;
                            d.dr_be   = req_be;
                            d.rd_req  = 1'b1;
                            d.stop_n  = 1'b0;
                        end
                    end else begin
                        d.rd_req = 1'b1;
                        tmr_load = 1'b1;
                        d.st     = ST_WAIT;
                    end
                end
            end
            ST_WAIT: begin
                if (lcl_data_rdy) begin
                    d.trdy_n = 1'b0;
                    d.st     = ST_IDLE;
                end else if (tmr_expired) begin
                    d.stop_n = 1'b0;
                    d.st     = ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st      <= ST_IDLE;
            q.trdy_n  <= 1'b1;
            q.stop_n  <= 1'b1;
            q.rd_req  <= 1'b0;
            q.dr_pend <= 1'b0;
            q.dr_rdy  <= 1'b0;
            q.dr_addr <= '0;
            q.dr_be   <= '0;
        end else begin
            q <= d;
        end
    end

    assign trdy_n     = q.trdy_n;
    assign stop_n     = q.stop_n;
    assign lcl_rd_req = q.rd_req;
    assign dr_pending = q.dr_pend;
endmodule

// File: rtl/rdrt_chk.sv
module rdrt_chk #(
    parameter int FIFO_DEPTH = 8,
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_compliant,
    input logic             cfg_flush,
    input logic             cfg_reserve,
    input logic             req_start,
    input logic             req_write,
    input logic [CNT_W-1:0] wf_count,
    input logic             lcl_rd_req,
    input logic             trdy_n,
    input logic             stop_n,
    input logic             dr_pending
);
    // R11
    resp_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!trdy_n && !stop_n));

    // R11
    trdy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |=> trdy_n);

    // R11
    stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |=> stop_n);

    // R2
    dr_first_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !req_write && cfg_compliant && !dr_pending && !lcl_rd_req
         && (cfg_reserve || wf_count < CNT_W'(FIFO_DEPTH)))
        |=> (!stop_n && lcl_rd_req && dr_pending));

    // R7
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && req_write && cfg_compliant && cfg_flush) |=> !dr_pending);

    // R10
    full_read_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_start && !req_write && !cfg_reserve && wf_count >= CNT_W'(FIFO_DEPTH))
        |=> (!stop_n && !lcl_rd_req));
endmodule

bind pci_rd_retry_ctl rdrt_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_rdrt_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_compliant (cfg_compliant),
    .cfg_flush     (cfg_flush),
    .cfg_reserve   (cfg_reserve),
    .req_start     (req_start),
    .req_write     (req_write),
    .wf_count      (wf_count),
    .lcl_rd_req    (lcl_rd_req),
    .trdy_n        (trdy_n),
    .stop_n        (stop_n),
    .dr_pending    (dr_pending)
);

// File: tb/pci_rd_retry_ctl_bench.sv
module pci_rd_retry_ctl_bench;
    localparam int ADDR_W = 16;
    localparam int BE_W = 4;
    localparam int DEPTH = 4;
    localparam int CW = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_compliant = 1'b0, cfg_flush = 1'b0, cfg_reserve = 1'b0;
    logic [3:0] cfg_retry_dly = 4'd0;
    logic req_start = 1'b0, req_write = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [BE_W-1:0] req_be = '0;
    logic [CW-1:0] wf_count = '0;
    logic lcl_data_rdy = 1'b0;
    logic lcl_rd_req, trdy_n, stop_n, dr_pending;

    int errors = 0;
    int checks = 0;
    int r_lat;
    logic r_trdy, r_stop, r_rdreq;

    always #4 clk = ~clk;

    pci_rd_retry_ctl #(.ADDR_W(ADDR_W), .BE_W(BE_W), .FIFO_DEPTH(DEPTH)) u_pci_rd_retry_ctl (
        .clk (clk), .rst_n (rst_n),
        .cfg_compliant (cfg_compliant), .cfg_flush (cfg_flush),
        .cfg_reserve (cfg_reserve), .cfg_retry_dly (cfg_retry_dly),
        .req_start (req_start), .req_write (req_write),
        .req_addr (req_addr), .req_be (req_be),
        .wf_count (wf_count), .lcl_data_rdy (lcl_data_rdy),
        .lcl_rd_req (lcl_rd_req), .trdy_n (trdy_n),
        .stop_n (stop_n), .dr_pending (dr_pending)
    );

    // [7] compliant [6] reserve [5] write [4:2] count [1] exp trdy_n [0] exp stop_n
    localparam logic [7:0] VEC [8] = '{
        {1'b0, 1'b0, 1'b1, 3'd3, 1'b0, 1'b1},
        {1'b0, 1'b0, 1'b1, 3'd4, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 3'd3, 1'b1, 1'b0},
        {1'b0, 1'b1, 1'b1, 3'd2, 1'b0, 1'b1},
        {1'b0, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b0, 3'd4, 1'b1, 1'b0},
        {1'b1, 1'b1, 1'b1, 3'd4, 1'b1, 1'b0},
        {1'b1, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1}
    };

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic do_req(input bit wr, input logic [ADDR_W-1:0] a,
                          input logic [BE_W-1:0] be, input int data_at);
        int lat;
        @(negedge clk);
        req_start = 1'b1; req_write = wr; req_addr = a; req_be = be;
        @(posedge clk); #1;
        req_start = 1'b0;
        lat = 0;
        r_rdreq = lcl_rd_req;
        while (trdy_n && stop_n && lat < 300) begin
            lcl_data_rdy = (lat + 1 == data_at);
            @(posedge clk); #1;
            lat++;
        end
        lcl_data_rdy = 1'b0;
        r_lat = lat; r_trdy = !trdy_n; r_stop = !stop_n;
        @(posedge clk); #1;
        chk(trdy_n && stop_n, "R11", "one-cycle pulse", {trdy_n, stop_n}, 3);
    endtask

    task automatic pulse_data();
        @(negedge clk); lcl_data_rdy = 1'b1;
        @(negedge clk); lcl_data_rdy = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk(trdy_n && stop_n, "R1", "reset responses", {trdy_n, stop_n}, 3);
        chk(!lcl_rd_req && !dr_pending, "R1", "reset req/pending", {lcl_rd_req, dr_pending}, 0);
        @(negedge clk); rst_n = 1'b1;

        // occupancy table: R9 (reserve) and R10 (no reserve)
        foreach (VEC[i]) begin
            @(negedge clk);
            cfg_compliant = VEC[i][7]; cfg_reserve = VEC[i][6]; wf_count = VEC[i][4:2];
            do_req(VEC[i][5], 16'h0100, 4'hF, -1);
            chk(r_lat == 0 && r_trdy == !VEC[i][1] && r_stop == !VEC[i][0],
                VEC[i][6] ? "R9" : "R10", $sformatf("vector %0d response", i),
                {r_trdy, r_stop}, {!VEC[i][1], !VEC[i][0]});
            if (!VEC[i][5])
                chk(!r_rdreq, "R10", "blocked read no fetch", r_rdreq, 0);
        end
        do_reset();

        // compliant delayed read
        cfg_compliant = 1'b1; cfg_reserve = 1'b0; cfg_flush = 1'b0; wf_count = '0;
        do_req(1'b0, 16'h1230, 4'hF, -1);
        chk(r_stop && r_lat == 0 && r_rdreq, "R2", "first read retried+fetch", r_lat, 0);
        chk(dr_pending, "R2", "pending set", dr_pending, 1);
        do_req(1'b0, 16'h1230, 4'hF, -1);
        chk(r_stop && !r_trdy, "R3", "repeat before data retried", r_trdy, 0);
        do_req(1'b0, 16'h4560, 4'hF, -1);
        chk(r_stop && !r_rdreq && dr_pending, "R4", "other addr retried", r_rdreq, 0);
        do_req(1'b0, 16'h1230, 4'h3, -1);
        chk(r_stop && !r_rdreq && dr_pending, "R4", "other be retried", r_rdreq, 0);
        pulse_data();
        do_req(1'b0, 16'h1230, 4'hF, -1);
        chk(r_trdy && r_lat == 0, "R3", "repeat after data completes", r_trdy, 1);
        chk(!dr_pending, "R3", "pending cleared", dr_pending, 0);

        // flush
        do_req(1'b0, 16'h2000, 4'hF, -1);
        @(negedge clk); cfg_flush = 1'b1;
        do_req(1'b1, 16'h3000, 4'hF, -1);
        chk(r_trdy && !dr_pending, "R7", "write flushes pending", dr_pending, 0);
        do_req(1'b0, 16'h2000, 4'hF, -1);
        chk(r_stop && r_rdreq, "R7", "read after flush refetches", r_rdreq, 1);

        // no flush
        @(negedge clk); cfg_flush = 1'b0;
        pulse_data();
        do_req(1'b1, 16'h3000, 4'hF, -1);
        chk(r_trdy && dr_pending, "R8", "write keeps pending", dr_pending, 1);
        do_req(1'b0, 16'h2000, 4'hF, -1);
        chk(r_trdy && r_lat == 0, "R8", "fetched data kept", r_trdy, 1);

        // legacy hold mode
        @(negedge clk); cfg_compliant = 1'b0; cfg_retry_dly = 4'd1;
        do_req(1'b0, 16'h0040, 4'hF, 3);
        chk(r_trdy && r_lat == 3, "R5", "data at edge 3", r_lat, 3);
        chk(r_rdreq, "R5", "legacy fetch pulse", r_rdreq, 1);
        do_req(1'b0, 16'h0040, 4'hF, -1);
        chk(r_stop && r_lat == 9, "R6", "timeout dly=1", r_lat, 9);
        do_req(1'b0, 16'h0040, 4'hF, 9);
        chk(r_trdy && r_lat == 9, "R5", "data on expiry edge wins", r_lat, 9);
        @(negedge clk); cfg_retry_dly = 4'd2;
        do_req(1'b0, 16'h0040, 4'hF, -1);
        chk(r_stop && r_lat == 17, "R6", "timeout dly=2", r_lat, 17);
        @(negedge clk); cfg_retry_dly = 4'd0;
        do_req(1'b0, 16'h0040, 4'hF, -1);
        chk(r_stop && r_lat == 1, "R6", "timeout dly=0", r_lat, 1);

        // reserve: read at full occupancy still served
        @(negedge clk); cfg_reserve = 1'b1; wf_count = 3'd4; cfg_retry_dly = 4'd1;
        do_req(1'b0, 16'h0080, 4'hF, 2);
        chk(r_trdy && r_lat == 2, "R9", "read at full with reserve", r_lat, 2);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #800000;
        errors++; checks++;
        $display("FAIL watchdog expired: actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule